// File: doc/BRIEF.md
# Low-Power Mode Status and Control Register

This block is one 8-bit memory-mapped register that sits beside a processor core's low-power sequencer. Two of its bits are sticky flags. Hardware sets one when the core enters stop mode and the other when it enters wait mode. Software can only clear them. They survive a hardware reset and a software reset, and only a power-on reset wipes them. Startup firmware reads them to tell a cold start from a warm reset, and to learn whether a reset ended a stop or wait period.

The other implemented bits are ordinary read/write controls, each driven out on its own registered pin:
- standby-state select
- system-clock gating while in wait mode
- address-output policy
- counter source select

Any of the three reset kinds returns these controls to 0. The two remaining bit positions are unimplemented.

Reads are combinational from the stored bits. A write takes effect on the clock edge where the write strobe is high.

Top module: `lpm_status_reg`

## Requirements
- R1: While porRst is high at a clock edge, every register bit becomes 0, so rdData reads 0x00 after that edge.
- R2: A one-cycle stopEnter pulse, with no hardware, software or power-on reset in that cycle, makes bit 0 of rdData read 1 after that edge.
- R3: A one-cycle waitEnter pulse, with no reset in that cycle, makes bit 1 of rdData read 1 after that edge.
- R4: A write with a 0 in bit 0 or bit 1 clears that flag. A 1 in that position leaves the flag unchanged.
- R5: A hardware reset (hwRst) or a software reset (swRst) clears the control bits (2, 3, 4, 6) and leaves both flags at their previous value. Entry pulses in that cycle are ignored.
- R6: When an entry pulse and a write of 0 to the same flag occur in one cycle, the flag reads 1 afterwards.
- R7: Writes load control bits 2 (standbySel), 3 (waitClkOff: 1 stops the system clock in wait mode, 0 keeps it running), 4 (addrExtOnly: 1 means the address changes only on external accesses) and 6 (cntSrcSel). Each value appears on its output pin after the write edge.
- R8: Bits 5 and 7 of rdData always read 0, whatever is written.
- R9: rdData changes only at the clock edge that follows a write, never in the same cycle as the write.
- R10: Writing 1 to a flag that is 0 never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| porRst | input | 1 | Power-on reset, synchronous, active high |
| hwRst | input | 1 | Hardware (pin) reset, synchronous, active high |
| swRst | input | 1 | Software reset, synchronous, active high |
| wrEn | input | 1 | Write strobe for this register |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Current register contents |
| stopEnter | input | 1 | One-cycle pulse on stop-mode entry |
| waitEnter | input | 1 | One-cycle pulse on wait-mode entry |
| standbySel | output | 1 | Standby state select control |
| waitClkOff | output | 1 | 1 gates the system clock while in wait mode |
| addrExtOnly | output | 1 | 1 keeps the address steady on internal accesses |
| cntSrcSel | output | 1 | Counter clock source select |

## Verification
A corrupted flag shows on rdData bit 0 or bit 1 at the first read after the faulty edge. A flag lost across a warm reset therefore surfaces one cycle after hwRst or swRst. A wrong control bit shows at once on both its pin and its rdData position, because the two come from the same flop. An inverted write priority shows only in the cycle where an entry pulse coincides with a clearing write, so that collision is driven on purpose.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int DATA_W = 8;
  localparam int STOP_POS = 0;
  localparam int WAIT_POS = 1;
  localparam int CTL_N = 4;
  localparam int CTL_POS [CTL_N] = '{2, 3, 4, 6};

  typedef struct packed {
    logic setStop;
    logic setWait;
    logic clrStop;
    logic clrWait;
    logic ldCtl;
    logic clrCtl;
  } lpm_strobe_t;
endpackage

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic              hwRst,
  input  logic              swRst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              stopEnter,
  input  logic              waitEnter,
  output lpm_strobe_t       stb
);
  logic warmRst;

  always_comb begin
    warmRst     = hwRst | swRst;
    stb.clrCtl  = warmRst;
    stb.ldCtl   = wrEn & ~warmRst;
    stb.setStop = stopEnter & ~warmRst;
    stb.setWait = waitEnter & ~warmRst;
    // hardware set beats a software clear in the same cycle
    stb.clrStop = wrEn & ~wrData[STOP_POS] & ~stb.setStop & ~warmRst;
    stb.clrWait = wrEn & ~wrData[WAIT_POS] & ~stb.setWait & ~warmRst;
  end
endmodule

// File: rtl/lpm_regs.sv
module lpm_regs
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              porRst,
  input  lpm_strobe_t       stb,
  input  logic [DATA_W-1:0] wrData,
  output logic              stopFlag,
  output logic              waitFlag,
  output logic [CTL_N-1:0]  ctlBits,
  output logic [DATA_W-1:0] rdData
);
  always_ff @(posedge clk) begin
    if (porRst) begin
      stopFlag <= 1'b0;
      waitFlag <= 1'b0;
    end else begin
      if (stb.setStop)      stopFlag <= 1'b1;
      else if (stb.clrStop) stopFlag <= 1'b0;
      if (stb.setWait)      waitFlag <= 1'b1;
      else if (stb.clrWait) waitFlag <= 1'b0;
    end
  end

  for (genvar i = 0; i < CTL_N; i++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (porRst || stb.clrCtl) ctlBits[i] <= 1'b0;
      else if (stb.ldCtl)       ctlBits[i] <= wrData[CTL_POS[i]];
    end
  end

  always_comb begin
    rdData = '0;
    rdData[STOP_POS] = stopFlag;
    rdData[WAIT_POS] = waitFlag;
    for (int i = 0; i < CTL_N; i++) rdData[CTL_POS[i]] = ctlBits[i];
  end

  // R2
  stop_set_chk: assert property (@(posedge clk) disable iff (porRst)
    stb.setStop |=> stopFlag);
  // R3
  wait_set_chk: assert property (@(posedge clk) disable iff (porRst)
    stb.setWait |=> waitFlag);
  // R10
  stop_nosetsw_chk: assert property (@(posedge clk) disable iff (porRst)
    (!stopFlag && !stb.setStop) |=> !stopFlag);
  // R10
  wait_nosetsw_chk: assert property (@(posedge clk) disable iff (porRst)
    (!waitFlag && !stb.setWait) |=> !waitFlag);
  // R5
  warm_hold_chk: assert property (@(posedge clk) disable iff (porRst)
    stb.clrCtl |=> ($stable(stopFlag) && $stable(waitFlag) && ctlBits == '0));
endmodule

// File: rtl/lpm_status_reg.sv
module lpm_status_reg
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              porRst,
  input  logic              hwRst,
  input  logic              swRst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              stopEnter,
  input  logic              waitEnter,
  output logic              standbySel,
  output logic              waitClkOff,
  output logic              addrExtOnly,
  output logic              cntSrcSel
);
  lpm_strobe_t        stb;
  logic               stopFlag;
  logic               waitFlag;
  logic [CTL_N-1:0]   ctlBits;

  lpm_ctrl u_ctrl (
    .hwRst(hwRst), .swRst(swRst), .wrEn(wrEn), .wrData(wrData),
    .stopEnter(stopEnter), .waitEnter(waitEnter), .stb(stb)
  );

  lpm_regs u_regs (
    .clk(clk), .porRst(porRst), .stb(stb), .wrData(wrData),
    .stopFlag(stopFlag), .waitFlag(waitFlag), .ctlBits(ctlBits),
    .rdData(rdData)
  );

  assign standbySel  = ctlBits[0];
  assign waitClkOff  = ctlBits[1];
  assign addrExtOnly = ctlBits[2];
  assign cntSrcSel   = ctlBits[3];

  // R1
  por_clear_chk: assert property (@(posedge clk) porRst |=> rdData == '0);
  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (porRst)
    (stopEnter && wrEn && !wrData[STOP_POS] && !hwRst && !swRst) |=> rdData[STOP_POS]);
  // R9
  write_late_chk: assert property (@(posedge clk) disable iff (porRst)
    (!wrEn && !stopEnter && !waitEnter && !hwRst && !swRst) |=> $stable(rdData));
endmodule

// File: tb/lpm_status_reg_test.sv
`timescale 1ns/1ps
module lpm_status_reg_test;
  logic clk = 1'b0;
  logic porRst, hwRst, swRst, wrEn, stopEnter, waitEnter;
  logic [7:0] wrData, rdData;
  logic standbySel, waitClkOff, addrExtOnly, cntSrcSel;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sbq[$];

  logic [7:0] model = 8'h00;

  always #2 clk = ~clk;

  lpm_status_reg uut (
    .clk(clk), .porRst(porRst), .hwRst(hwRst), .swRst(swRst),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .stopEnter(stopEnter), .waitEnter(waitEnter),
    .standbySel(standbySel), .waitClkOff(waitClkOff),
    .addrExtOnly(addrExtOnly), .cntSrcSel(cntSrcSel)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // Driver: computes the expected register value from the requirements.
  task automatic step(input logic por, input logic hw, input logic sw,
                      input logic we, input logic [7:0] wd,
                      input logic se, input logic wt, input string tag);
    logic [7:0] nxt;
    @(negedge clk);
    porRst = por; hwRst = hw; swRst = sw; wrEn = we; wrData = wd;
    stopEnter = se; waitEnter = wt;
    nxt = model;
    if (por) nxt = 8'h00;                           // R1
    else if (hw || sw) nxt = model & 8'h03;         // R5
    else begin
      if (we) begin
        nxt = (wd & 8'h5C) | (model & 8'h03);       // R7 R8
        if (!wd[0]) nxt[0] = 1'b0;                  // R4
        if (!wd[1]) nxt[1] = 1'b0;                  // R4 R10
      end
      if (se) nxt[0] = 1'b1;                        // R2 R6
      if (wt) nxt[1] = 1'b1;                        // R3
    end
    #0.5;
    if (!por) check(rdData, model, {tag, " R9 read before edge"});
    model = nxt;
    sbq.push_back('{exp: nxt, tag: tag});
  endtask

  // Monitor: compares each edge's result against the queued expectation.
  always @(posedge clk) begin
    #1;
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      check(rdData, it.exp, it.tag);
      check({cntSrcSel, addrExtOnly, waitClkOff, standbySel},
            {it.exp[6], it.exp[4], it.exp[3], it.exp[2]}, {it.tag, " R7 pins"});
    end
  end

  initial begin
    #20000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    porRst = 1; hwRst = 0; swRst = 0; wrEn = 0; wrData = 0;
    stopEnter = 0; waitEnter = 0;
    step(1, 0, 0, 0, 8'h00, 0, 0, "R1 power-on");
    step(0, 0, 0, 1, 8'hFF, 0, 0, "R8 R10 write all ones");
    step(0, 0, 0, 0, 8'h00, 1, 0, "R2 stop entry");
    step(0, 0, 0, 0, 8'h00, 0, 1, "R3 wait entry");
    step(0, 0, 0, 1, 8'h5F, 0, 0, "R4 write one keeps flags");
    step(0, 0, 0, 1, 8'h5E, 0, 0, "R4 clear stop flag");
    step(0, 1, 0, 0, 8'h00, 0, 0, "R5 hardware reset");
    step(0, 0, 0, 0, 8'h00, 1, 0, "R2 stop entry again");
    step(0, 0, 1, 0, 8'h00, 0, 0, "R5 software reset");
    step(0, 0, 0, 1, 8'h00, 1, 0, "R6 set beats clear");
    step(0, 0, 0, 1, 8'h09, 0, 0, "R7 wait clock off");
    step(0, 0, 0, 1, 8'hB1, 0, 0, "R7 R8 mixed controls");
    step(0, 1, 0, 0, 8'h00, 0, 1, "R5 entry ignored in reset");
    step(0, 0, 0, 1, 8'h02, 0, 0, "R10 write one to clear flag");
    step(0, 0, 0, 0, 8'h00, 0, 1, "R3 wait entry again");
    step(1, 0, 0, 0, 8'h00, 0, 0, "R1 power-on clears flags");
    step(0, 0, 0, 0, 8'h00, 0, 0, "R1 idle after power-on");
    @(negedge clk);
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule